// File: doc/BRIEF.md
# Tone Guard-Time Steering Qualifier

This block sits behind a dual-tone detector and decides when a detected tone pair counts as a real digit. Each cycle the detector offers a raw "pair detected" flag and a 4-bit code. The block turns that noisy flag into a clean steering level. It uses two guard durations, each a count of clock ticks, and they are programmed separately. One sets how long a tone must persist before it is accepted. The other sets how long silence must persist before the tone is released.

Each guard restarts from scratch on any interruption. A short burst of detection during a pause therefore never produces a digit. A short dropout during an accepted tone is bridged: steering stays high and no second digit is reported.

When a tone is accepted, three things happen in the same cycle. The code is latched onto the receive outputs, steering rises, and a one-cycle new-digit strobe is raised for the status logic. A delayed-steering level reports that the tone's absence has been validated.

The qualifier is a four-state machine:
- ST_IDLE: no tone, steering low.
- ST_ARMING: the presence guard is counting.
- ST_PRESENT: steering high and detection present.
- ST_HOLDING: steering high, detection lost, and the absence guard counting.

Its transitions are:
- IDLE→ARMING: detection seen and the presence guard is nonzero.
- IDLE→PRESENT: detection seen and the presence guard is zero.
- ARMING→ARMING: the code changed, so the presence guard restarts.
- ARMING→IDLE: detection dropped.
- ARMING→PRESENT: the presence guard expired.
- PRESENT→HOLDING: detection lost and the absence guard is nonzero.
- PRESENT→IDLE: detection lost and the absence guard is zero.
- HOLDING→PRESENT: detection returned, so the dropout is bridged.
- HOLDING→IDLE: the absence guard expired.

Top module: `tone_steer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces `steer` to 0, `delayed_steer` to 1, `rx_code` to 0 and `new_digit` to 0.
- R2: From the idle state, `steer` rises at the clock edge that samples `det_valid` high for the (P+1)-th consecutive time with an unchanged code, where P is `pres_ticks`. With P equal to 0, it rises at the first edge that samples the flag high.
- R3: A run of P or fewer consecutive high samples of `det_valid`, followed by a low sample, produces no rise of `steer` and no `new_digit`. The next high sample starts the presence count from one again.
- R4: While the presence count runs, a change of `det_code` between sampled edges restarts the count. The new code then needs P+1 consecutive samples of its own before it is accepted.
- R5: At acceptance, `rx_code` takes the value of `det_code` sampled at the accepting edge. It holds that value unchanged until the next acceptance.
- R6: `new_digit` is high for exactly the one cycle after the accepting edge, which is also the cycle in which `steer` first reads 1. There is exactly one pulse per accepted tone.
- R7: Once accepted, `steer` falls at the edge that samples `det_valid` low for the (A+1)-th consecutive time, where A is `abs_ticks`. A low gap of A samples or fewer keeps `steer` high, raises no `new_digit`, and restarts the absence count at its next low sample.
- R8: `delayed_steer` is set at the edge where absence is validated and cleared at the edge where presence is validated. It therefore always reads as the inverse of `steer`.
- R9: While `steer` is high, code changes on `det_code` are ignored. No further `new_digit` occurs until absence has been validated (R7) and a fresh tone is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| det_valid | input | 1 | Raw per-cycle tone-pair-detected flag from the detector |
| det_code | input | 4 | Decoded tone code from the detector |
| pres_ticks | input | 16 | Presence guard P in clock ticks; 0 accepts at the first high sample |
| abs_ticks | input | 16 | Absence guard A in clock ticks; 0 releases at the first low sample |
| steer | output | 1 | Qualified steering: 1 while a validated tone is held |
| delayed_steer | output | 1 | Validated-absence indication |
| rx_code | output | 4 | Code latched at the last acceptance |
| new_digit | output | 1 | One-cycle strobe on acceptance of a tone |

## Verification
A wrong counter value or a stuck state shows up at the ports as a strobe that arrives early or late. It can also show up as a missing or doubled strobe. The scoreboard records the exact cycle each strobe is due, so such a fault is reported in the very cycle the strobe should or should not have appeared. After every tone and gap, the bench compares the steering level, the delayed-steering level and the latched code against its own model. A state machine stuck in the holding or arming state is therefore caught before the next tone starts. The exact-length tone runs and the code change during arming place every counter boundary off by one edge.

// File: rtl/tone_steer_pkg.sv
package tone_steer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMING  = 2'd1,
        ST_PRESENT = 2'd2,
        ST_HOLDING = 2'd3
    } steer_state_e;

    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_LOAD1 = 2'd1,
        CNT_INC   = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/tone_steer_cnt.sv
// Shared guard counter. It counts consecutive samples and compares them against the active limit.
module tone_steer_cnt
    import tone_steer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                CNT_LOAD1: cnt_q <= ONE;
                CNT_INC:   cnt_q <= cnt_q + ONE;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    assign expired = (cnt_q >= limit);
endmodule

// File: rtl/tone_steer_cand.sv
// Holds the candidate code while the presence guard runs.
module tone_steer_cand #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] det_code,
    output logic              code_match
);
    logic [CODE_W-1:0] cand_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q <= '0;
        end else if (load) begin
            cand_q <= det_code;
        end
    end

    assign code_match = (cand_q == det_code);
endmodule

// File: rtl/tone_steer_fsm.sv
// Guard-time state machine: a state register and next-state/event logic.
module tone_steer_fsm
    import tone_steer_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         det_valid,
    input  logic         code_match,
    input  logic         expired,
    input  logic         pres_zero,
    input  logic         abs_zero,
    output steer_state_e state_q,
    output cnt_op_e      cnt_op,
    output logic         cand_load,
    output logic         ev_accept,
    output logic         ev_release
);
    steer_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        cnt_op     = CNT_HOLD;
        cand_load  = 1'b0;
        ev_accept  = 1'b0;
        ev_release = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (det_valid) begin
                    if (pres_zero) begin
                        state_d   = ST_PRESENT;
                        ev_accept = 1'b1;
                    end else begin
                        state_d   = ST_ARMING;
                        cnt_op    = CNT_LOAD1;
                        cand_load = 1'b1;
                    end
                end
            end
            ST_ARMING: begin
                if (!det_valid) begin
                    state_d = ST_IDLE;
                end else if (!code_match) begin
                    cnt_op    = CNT_LOAD1;
                    cand_load = 1'b1;
                end else if (expired) begin
                    state_d   = ST_PRESENT;
                    ev_accept = 1'b1;
                end else begin
                    cnt_op = CNT_INC;
                end
            end
            ST_PRESENT: begin
                if (!det_valid) begin
                    if (abs_zero) begin
                        state_d    = ST_IDLE;
                        ev_release = 1'b1;
                    end else begin
                        state_d = ST_HOLDING;
                        cnt_op  = CNT_LOAD1;
                    end
                end
            end
            ST_HOLDING: begin
                if (det_valid) begin
                    state_d = ST_PRESENT;
                end else if (expired) begin
                    state_d    = ST_IDLE;
                    ev_release = 1'b1;
                end else begin
                    cnt_op = CNT_INC;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/tone_steer_out.sv
// Registered outputs: steering, delayed steering, code latch and strobe.
module tone_steer_out #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_accept,
    input  logic              ev_release,
    input  logic [CODE_W-1:0] det_code,
    output logic              steer,
    output logic              delayed_steer,
    output logic [CODE_W-1:0] rx_code,
    output logic              new_digit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            steer         <= 1'b0;
            delayed_steer <= 1'b1;
            rx_code       <= '0;
            new_digit     <= 1'b0;
        end else begin
            new_digit <= ev_accept;
            if (ev_accept) begin
                steer         <= 1'b1;
                delayed_steer <= 1'b0;
                rx_code       <= det_code;
            end else if (ev_release) begin
                steer         <= 1'b0;
                delayed_steer <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tone_steer.sv
module tone_steer
    import tone_steer_pkg::*;
#(
    parameter int CODE_W  = 4,
    parameter int GUARD_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               det_valid,
    input  logic [CODE_W-1:0]  det_code,
    input  logic [GUARD_W-1:0] pres_ticks,
    input  logic [GUARD_W-1:0] abs_ticks,
    output logic               steer,
    output logic               delayed_steer,
    output logic [CODE_W-1:0]  rx_code,
    output logic               new_digit
);
    steer_state_e       state_q;
    cnt_op_e            cnt_op;
    logic               cand_load;
    logic               code_match;
    logic               expired;
    logic               ev_accept;
    logic               ev_release;
    logic [GUARD_W-1:0] limit;

    // The absence guard applies only while holding; otherwise the presence guard applies.
    assign limit = (state_q == ST_HOLDING) ? abs_ticks : pres_ticks;

    tone_steer_cnt #(.CNT_W(GUARD_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .op      (cnt_op),
        .limit   (limit),
        .expired (expired)
    );

    tone_steer_cand #(.CODE_W(CODE_W)) u_cand (
        .clk        (clk),
        .rst        (rst),
        .load       (cand_load),
        .det_code   (det_code),
        .code_match (code_match)
    );

    tone_steer_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .det_valid  (det_valid),
        .code_match (code_match),
        .expired    (expired),
        .pres_zero  (pres_ticks == '0),
        .abs_zero   (abs_ticks == '0),
        .state_q    (state_q),
        .cnt_op     (cnt_op),
        .cand_load  (cand_load),
        .ev_accept  (ev_accept),
        .ev_release (ev_release)
    );

    tone_steer_out #(.CODE_W(CODE_W)) u_out (
        .clk           (clk),
        .rst           (rst),
        .ev_accept     (ev_accept),
        .ev_release    (ev_release),
        .det_code      (det_code),
        .steer         (steer),
        .delayed_steer (delayed_steer),
        .rx_code       (rx_code),
        .new_digit     (new_digit)
    );
endmodule

// File: rtl/tone_steer_chk.sv
module tone_steer_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              det_valid,
    input logic [CODE_W-1:0] det_code,
    input logic              steer,
    input logic              delayed_steer,
    input logic [CODE_W-1:0] rx_code,
    input logic              new_digit
);
    AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        new_digit |-> (steer && !$past(steer)));                     // R6
    AST_RISE_HAS_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(steer) |-> new_digit);                                  // R6
    AST_RISE_NEEDS_DET: assert property (@(posedge clk) disable iff (rst)
        $rose(steer) |-> $past(det_valid));                           // R2
    AST_FALL_NEEDS_SILENCE: assert property (@(posedge clk) disable iff (rst)
        $fell(steer) |-> !$past(det_valid));                          // R7
    AST_DELAYED_INVERSE: assert property (@(posedge clk) disable iff (rst)
        delayed_steer == !steer);                                     // R8
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !new_digit |-> $stable(rx_code));                             // R5
    AST_CODE_CAPTURED: assert property (@(posedge clk) disable iff (rst)
        new_digit |-> (rx_code == $past(det_code)));                  // R5
endmodule

bind tone_steer tone_steer_chk #(.CODE_W(CODE_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .det_valid     (det_valid),
    .det_code      (det_code),
    .steer         (steer),
    .delayed_steer (delayed_steer),
    .rx_code       (rx_code),
    .new_digit     (new_digit)
);

// File: tb/sim_tone_steer.sv
module sim_tone_steer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        det_valid = 1'b0;
    logic [3:0]  det_code = 4'h0;
    logic [15:0] pres_ticks = 16'd3;
    logic [15:0] abs_ticks = 16'd2;
    logic        steer, delayed_steer, new_digit;
    logic [3:0]  rx_code;

    always #10 clk = ~clk;   // 50 MHz

    tone_steer u0 (
        .clk(clk), .rst(rst), .det_valid(det_valid), .det_code(det_code),
        .pres_ticks(pres_ticks), .abs_ticks(abs_ticks),
        .steer(steer), .delayed_steer(delayed_steer),
        .rx_code(rx_code), .new_digit(new_digit)
    );

    typedef struct { logic [3:0] code; int at; } exp_t;
    exp_t q[$];

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   armed = 1'b1;
    bit   done = 1'b0;
    logic [3:0] last_code = 4'h0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: each strobe must match the next scoreboard entry in both code and cycle.
    always @(negedge clk) begin
        if (!rst && new_digit) begin
            if (q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R6/R9 unexpected strobe actual_code=%0d expected=none", rx_code);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk("R5 strobe code", int'(rx_code), int'(e.code));
                chk("R2 strobe cycle", cyc, e.at);
            end
        end
    end

    // Driver: called just after a falling edge. It drives h high samples, then l low samples.
    task automatic play(input logic [3:0] code, input int h, input int l, input string tag);
        det_valid = 1'b1;
        det_code  = code;
        if (armed && h >= int'(pres_ticks) + 1) begin
            exp_t e;
            e.code = code;
            e.at   = cyc + 1 + int'(pres_ticks);
            q.push_back(e);
            armed = 1'b0;
            last_code = code;
        end
        repeat (h) @(negedge clk);
        det_valid = 1'b0;
        repeat (l) @(negedge clk);
        if (l >= int'(abs_ticks) + 1) armed = 1'b1;
        chk({tag, " R7 steer"}, int'(steer), int'(!armed));
        chk({tag, " R8 delayed_steer"}, int'(delayed_steer), int'(armed));
        chk({tag, " R5 rx_code held"}, int'(rx_code), int'(last_code));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 steer", int'(steer), 0);
        chk("R1 delayed_steer", int'(delayed_steer), 1);
        chk("R1 rx_code", int'(rx_code), 0);
        chk("R1 new_digit", int'(new_digit), 0);
        rst = 1'b0;
        @(negedge clk);

        // R2: exactly P+1 high samples are accepted
        play(4'h5, 4, 3, "R2 exact");
        // R3: P high samples are rejected, and so is an interrupted run
        play(4'h7, 3, 3, "R3 short");
        play(4'h7, 2, 1, "R3 split a");
        play(4'h7, 2, 3, "R3 split b");
        // R7: a short dropout is bridged, with no second strobe
        play(4'h9, 6, 2, "R7 dropout");
        play(4'h9, 5, 4, "R7 resume");
        // R9: a code change while steering is high is ignored
        play(4'h3, 6, 0, "R9 accept");
        play(4'hC, 4, 3, "R9 change");
        // R4: a code change during arming restarts the presence count
        play(4'h1, 2, 0, "R4 first");
        play(4'h2, 4, 3, "R4 second");
        // R2/R7: zero guards accept and release at once
        pres_ticks = 16'd0; abs_ticks = 16'd0;
        play(4'hA, 1, 1, "R2 zero a");
        play(4'hB, 1, 1, "R2 zero b");
        // R2/R3: longer guards
        pres_ticks = 16'd20; abs_ticks = 16'd10;
        play(4'h6, 21, 11, "R2 long");
        play(4'hE, 20, 11, "R3 long short");
        play(4'hF, 25, 10, "R7 long hold");
        chk("R7 long hold still high", int'(steer), 1);
        play(4'h4, 3, 11, "R9 long bridge");

        repeat (5) @(negedge clk);
        chk("R6 all strobes seen", q.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule